// File: doc/BRIEF.md
# Serial Isolation Identifier Shifter

This block produces the bit-serial identifier stream that a card drives while the host isolates cards one at a time. The host reads the isolation register in pairs. The first read of each pair returns one bit of a 72-bit stream, and the second read returns that same response shifted left by one place. The stream holds the 64-bit card identifier, sent least-significant bit first, followed by an 8-bit checksum. A linear-feedback register builds the checksum as the identifier bits are shifted out.

When the checksum becomes final, the block emits a one-cycle store pulse. The pulse carries the checksum value and the fixed resource-memory offset where it is kept. After the last pair of reads, the block emits a one-cycle request to enter the configuration phase. In the same cycle it loads the resource pointer with a fixed resume offset. A wake command that matches the card's select number presets the checksum and restarts the pairing of reads.

Top module: `iso_id_shifter`

## Requirements
- R1: After reset, `rd_data` is 0x00, `cfg_req`, `ptr_load` and `sum_store` are low, the stream position is 0, the next read is a first read, and the checksum holds 0x6A.
- R2: A read while `iso_active` is low returns 0x00 and leaves position, pairing and checksum unchanged. The next isolation read therefore continues the stream where it stopped.
- R3: The first read of a pair returns 0x55 when the current stream bit is one and 0x00 when it is zero.
- R4: The second read of a pair returns the first read's response shifted left by one bit (0xAA or 0x00), and the position does not advance.
- R5: Stream positions 0 to 63 carry `ident[position]`, lowest bit first.
- R6: Stream positions 64 to 71 carry bit (position − 64) of the checksum register.
- R7: Each first read at positions 0 to 63 updates the checksum: it shifts right by one, and the new bit 7 is checksum bit 1 XOR checksum bit 0 XOR the identifier bit sent.
- R8: `wake_hit` presets the checksum to 0x6A and makes the next read a first read. The position is kept.
- R9: A second read that finds the position wrapped back to 0 pulses `cfg_req` and `ptr_load` for one cycle. `ptr_value` is 0x1B.
- R10: The first read at position 64 pulses `sum_store` for one cycle. `sum_value` is the finished checksum and `sum_addr` is 0x1A.
- R11: When `wake_hit` and `rd_stb` are high in the same cycle, the wake takes effect, the read returns 0x00 and the position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iso_active | input | 1 | Card is in the isolation phase |
| rd_stb | input | 1 | One-cycle read of the isolation register |
| wake_hit | input | 1 | Wake command matched this card's select number |
| ident | input | 64 | Card identifier |
| rd_data | output | 8 | Response to the latest read, held until the next read |
| cfg_req | output | 1 | Pulse: request the configuration phase |
| ptr_load | output | 1 | Pulse: load the resource pointer with `ptr_value` |
| ptr_value | output | 8 | Resume offset for the resource pointer |
| sum_store | output | 1 | Pulse: write the finished checksum |
| sum_addr | output | 8 | Resource-memory offset for the checksum |
| sum_value | output | 8 | Finished checksum |

## Verification
A wake can arrive in the same cycle as a read strobe. If the design mishandled this, it would advance the stream or hand back a stale byte while it was also resetting the checksum. The random phase of the bench asserts `wake_hit` together with `rd_stb` on some cycles, both inside and outside the isolation phase, and some of those cycles fall mid-pair. A reference model that gives the wake priority judges each case: the read must return 0x00, and the following read must be a first read at the unchanged position.

// File: rtl/iso_pkg.sv
package iso_pkg;
    typedef logic [7:0] byte_t;
    localparam byte_t ONE_PATTERN  = 8'h55;
    localparam byte_t ZERO_PATTERN = 8'h00;
endpackage

// File: rtl/iso_sum_lfsr.sv
module iso_sum_lfsr #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         din,
    output logic [W-1:0] nxt
);
    // shift toward bit 0, feedback enters at the top
    always_comb begin
        nxt = {cur[1] ^ cur[0] ^ din, cur[W-1:1]};
    end
endmodule

// File: rtl/iso_bit_pick.sv
module iso_bit_pick #(
    parameter int ID_W  = 64,
    parameter int SUM_W = 8,
    parameter int POS_W = 7
) (
    input  logic [POS_W-1:0] pos,
    input  logic [ID_W-1:0]  ident,
    input  logic [SUM_W-1:0] csum,
    output logic             in_id,
    output logic             bit_out
);
    localparam int ID_IDX_W  = (ID_W  > 1) ? $clog2(ID_W)  : 1;
    localparam int SUM_IDX_W = (SUM_W > 1) ? $clog2(SUM_W) : 1;
    localparam logic [POS_W-1:0] ID_END = POS_W'(ID_W);

    logic [ID_IDX_W-1:0]  id_idx;
    logic [SUM_IDX_W-1:0] sum_idx;

    always_comb begin
        in_id   = (pos < ID_END);
        id_idx  = ID_IDX_W'(pos);
        sum_idx = SUM_IDX_W'(pos - ID_END);
        bit_out = in_id ? ident[id_idx] : csum[sum_idx];
    end
endmodule

// File: rtl/iso_id_shifter.sv
module iso_id_shifter
    import iso_pkg::*;
#(
    parameter int          ID_W       = 64,
    parameter int          SUM_W      = 8,
    parameter logic [7:0]  SUM_SEED   = 8'h6A,
    parameter logic [7:0]  RESUME_PTR = 8'h1B,
    parameter logic [7:0]  SUM_SLOT   = 8'h1A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iso_active,
    input  logic             rd_stb,
    input  logic             wake_hit,
    input  logic [ID_W-1:0]  ident,
    output logic [7:0]       rd_data,
    output logic             cfg_req,
    output logic             ptr_load,
    output logic [7:0]       ptr_value,
    output logic             sum_store,
    output logic [7:0]       sum_addr,
    output logic [SUM_W-1:0] sum_value
);
    localparam int STREAM_LEN = ID_W + SUM_W;
    localparam int POS_W      = $clog2(STREAM_LEN);
    localparam logic [POS_W-1:0] ID_END   = POS_W'(ID_W);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(STREAM_LEN - 1);
    localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             pair;
        logic [SUM_W-1:0] csum;
        byte_t            shift;
        byte_t            rdata;
        logic             cfg;
        logic             sumwr;
        logic [SUM_W-1:0] sumval;
    } st_t;

    st_t st_d, st_q;

    logic             cur_bit;
    logic             cur_in_id;
    logic [SUM_W-1:0] csum_next;

    iso_bit_pick #(.ID_W(ID_W), .SUM_W(SUM_W), .POS_W(POS_W)) u_pick (
        .pos     (st_q.pos),
        .ident   (ident),
        .csum    (st_q.csum),
        .in_id   (cur_in_id),
        .bit_out (cur_bit)
    );

    iso_sum_lfsr #(.W(SUM_W)) u_lfsr (
        .cur (st_q.csum),
        .din (cur_bit),
        .nxt (csum_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.cfg   = 1'b0;
        st_d.sumwr = 1'b0;
        if (wake_hit) begin
            st_d.csum = SUM_W'(SUM_SEED);
            st_d.pair = 1'b0;
            if (rd_stb) st_d.rdata = ZERO_PATTERN;
        end else if (rd_stb && !iso_active) begin
            st_d.rdata = ZERO_PATTERN;
        end else if (rd_stb) begin
            if (!st_q.pair) begin
                if (cur_in_id) st_d.csum = csum_next;
                if (st_q.pos == ID_END) begin
                    st_d.sumwr  = 1'b1;
                    st_d.sumval = st_q.csum;
                end
                st_d.shift = cur_bit ? ONE_PATTERN : ZERO_PATTERN;
                st_d.pos   = (st_q.pos == LAST_POS) ? '0 : st_q.pos + POS_ONE;
            end else begin
                st_d.shift = st_q.shift << 1;
                if (st_q.pos == '0) st_d.cfg = 1'b1;
            end
            st_d.rdata = st_d.shift;
            st_d.pair  = ~st_q.pair;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos    <= '0;
            st_q.pair   <= 1'b0;
            st_q.csum   <= SUM_W'(SUM_SEED);
            st_q.shift  <= ZERO_PATTERN;
            st_q.rdata  <= ZERO_PATTERN;
            st_q.cfg    <= 1'b0;
            st_q.sumwr  <= 1'b0;
            st_q.sumval <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.rdata;
    assign cfg_req   = st_q.cfg;
    assign ptr_load  = st_q.cfg;
    assign ptr_value = RESUME_PTR;
    assign sum_store = st_q.sumwr;
    assign sum_addr  = SUM_SLOT;
    assign sum_value = st_q.sumval;

    // R2: idle-phase read yields zero and freezes the stream state
    p_idle_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !iso_active && !wake_hit |=>
            rd_data == 8'h00 && $stable(st_q.pos) && $stable(st_q.pair) && $stable(st_q.csum));

    // R3: first read answers with one of two patterns
    p_first_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && iso_active && !wake_hit && !st_q.pair |=>
            (rd_data == 8'h55 || rd_data == 8'h00));

    // R4: second read is the first response moved up one bit, position held
    p_second_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && iso_active && !wake_hit && st_q.pair |=>
            rd_data == 8'($past(st_q.shift) << 1) && $stable(st_q.pos));

    // R8: wake presets the checksum and restarts pairing
    p_wake_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit |=> st_q.csum == SUM_W'(SUM_SEED) && !st_q.pair);

    // R11: wake wins over a coincident read
    p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit && rd_stb |=> rd_data == 8'h00 && $stable(st_q.pos));

    // R9: configuration request only follows a qualifying read
    p_cfg_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> $past(rd_stb && iso_active && !wake_hit));

    // R10: checksum store happens right after the read at position 64
    p_sum_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sum_store |-> st_q.pos == ID_END + POS_ONE && st_q.pair);

    // R9 / R10: the two pulses never coincide
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_req, sum_store}));
endmodule

// File: tb/iso_id_shifter_test.sv
`timescale 1ns/1ps
module iso_id_shifter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iso_active = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wake_hit = 1'b0;
    logic [63:0] ident = '0;
    logic [7:0]  rd_data;
    logic        cfg_req, ptr_load, sum_store;
    logic [7:0]  ptr_value, sum_addr, sum_value;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    int         m_pos = 0;
    bit         m_pair = 1'b0;
    logic [7:0] m_cs = 8'h6A;
    logic [7:0] m_shift = 8'h00;
    logic [7:0] m_data = 8'h00;
    bit         woke = 1'b0;

    always #5 clk = ~clk;

    iso_id_shifter uut (
        .clk(clk), .rst_n(rst_n), .iso_active(iso_active), .rd_stb(rd_stb),
        .wake_hit(wake_hit), .ident(ident), .rd_data(rd_data), .cfg_req(cfg_req),
        .ptr_load(ptr_load), .ptr_value(ptr_value), .sum_store(sum_store),
        .sum_addr(sum_addr), .sum_value(sum_value)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sum_of(input logic [63:0] id);
        logic [7:0] c = 8'h6A;
        for (int i = 0; i < 64; i++) c = {c[1] ^ c[0] ^ id[i], c[7:1]};
        return c;
    endfunction

    // one cycle of stimulus, then compare against the reference model
    task automatic op(input bit rd, input bit wk, input bit iso);
        bit         e_cfg = 0, e_sum = 0, b;
        logic [7:0] e_sumv = 8'h00;
        string      tag = "R2";
        @(negedge clk);
        rd_stb = rd; wake_hit = wk; iso_active = iso;
        @(negedge clk);
        rd_stb = 1'b0; wake_hit = 1'b0;
        if (wk) begin
            m_cs = 8'h6A; m_pair = 0;
            if (rd) m_data = 8'h00;
            tag = "R11";
        end else if (rd && !iso) begin
            m_data = 8'h00;
            tag = "R2";
        end else if (rd) begin
            if (!m_pair) begin
                if (m_pos < 64) begin
                    b = ident[m_pos];
                    m_cs = {m_cs[1] ^ m_cs[0] ^ b, m_cs[7:1]};
                    tag = woke ? "R8" : "R5";
                end else begin
                    b = m_cs[m_pos - 64];
                    tag = woke ? "R8" : "R6";
                end
                if (m_pos == 64) begin e_sum = 1; e_sumv = m_cs; end
                m_shift = b ? 8'h55 : 8'h00;
                m_pos = (m_pos + 1) % 72;
                if (m_pos == 1 || m_pos == 65) tag = {tag, "/R3"};
            end else begin
                m_shift = m_shift << 1;
                if (m_pos == 0) e_cfg = 1;
                tag = "R4";
            end
            m_data = m_shift;
            m_pair = ~m_pair;
        end
        if (rd) check(tag, {24'h0, rd_data}, {24'h0, m_data});
        if (rd && !wk) woke = 1'b0;
        if (wk) woke = 1'b1;
        check("R9", {31'h0, cfg_req}, {31'h0, e_cfg});
        check("R9", {31'h0, ptr_load}, {31'h0, e_cfg});
        if (e_cfg) check("R9", {24'h0, ptr_value}, 32'h1B);
        check("R10", {31'h0, sum_store}, {31'h0, e_sum});
        if (e_sum) begin
            check("R10", {24'h0, sum_value}, {24'h0, e_sumv});
            check("R10", {24'h0, sum_addr}, 32'h1A);
        end
    endtask

    task automatic full_stream(input logic [63:0] id);
        ident = id;
        op(0, 1, 1);
        for (int p = 0; p < 72; p++) begin
            op(1, 0, 1);
            op(1, 0, 1);
        end
        // R7: checksum produced from the whole identifier
        check("R7", {24'h0, m_cs}, {24'h0, sum_of(id)});
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {24'h0, rd_data}, 32'h0);
        check("R1", {29'h0, cfg_req, ptr_load, sum_store}, 32'h0);

        ident = 64'h0123_4567_89AB_CDEF;
        // R2: reads outside isolation return zero and do not advance
        op(1, 0, 0);
        op(1, 0, 0);
        // R1: first isolation read is bit 0 with the reset-time checksum
        op(1, 0, 1);
        op(1, 0, 1);
        op(1, 0, 0);
        for (int p = 1; p < 72; p++) begin op(1, 0, 1); op(1, 0, 1); end
        check("R7", {24'h0, m_cs}, {24'h0, sum_of(64'h0123_4567_89AB_CDEF)});

        full_stream(64'hFFFF_FFFF_FFFF_FFFF);
        full_stream(64'h0);
        full_stream({$urandom, $urandom});

        // R8: wake mid-pair restarts pairing
        op(1, 0, 1);
        op(0, 1, 1);
        op(1, 0, 1);
        // R11: wake with read in the same cycle
        op(1, 1, 1);
        op(1, 0, 1);

        for (int k = 0; k < 3000; k++) begin
            int r = $urandom % 100;
            if (k % 500 == 0) ident = {$urandom, $urandom};
            op(r < 85, (r % 29) == 0, ($urandom % 10) != 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule